// File: doc/BRIEF.md
# Q15 Multiply-Accumulate Unit with Guard Bits

This block is a pipelined multiply-accumulate datapath for signed fractional numbers. Each operand is a 16-bit two's-complement value read as a fraction from -1.0 up to just under +1.0, so the integer code equals the value times 2^15. Two operands are multiplied into an exact 32-bit product. The product may then be shifted right arithmetically by a per-operation amount. The result is either written into the accumulator or added to it.

The accumulator is 40 bits wide. The 8 bits above the product width act as headroom, so long runs of products can be summed without losing the most significant part. A per-operation opcode selects what the unit does: clear the accumulator, load it with one shifted product (which starts a new sum without a separate clear cycle), add a shifted product to it, or read it out. A read returns the Q15 slice of the accumulator. When the read asks for saturation and the accumulator value does not fit in 16 bits, the read returns the extreme value of the same sign instead. A sticky flag records any wrap of the 40-bit accumulator itself.

The unit accepts one operation every clock. The multiply is registered in the first stage, and the shift and accumulate happen in the second.

Top module: `mac_q15`

## Requirements
- R1: In the cycle after a synchronous reset: `out_valid` is 0, `result` is 0x0000, `acc_ovf` is 0, and the accumulator holds zero, so a first read returns 0x0000.
- R2: The product of `a` and `b` is the exact signed 32-bit product, a Q30 value. Full-scale -1.0 times -1.0 gives +2^30.
- R3: The product is sign-extended to 40 bits and shifted right arithmetically by `shift` (0 to 15) before it reaches the accumulator. Bits shifted out are discarded, which truncates toward minus infinity.
- R4: `op` is decoded as follows. 2'b00 clears the accumulator. 2'b01 loads the shifted product. 2'b10 adds the shifted product. 2'b11 reads the accumulator and leaves it unchanged. A cycle with `in_valid` low changes nothing, whatever the other inputs carry.
- R5: A read accepted at clock edge k drives `out_valid` high with its `result` after edge k+1, that is two cycles after the operands are presented. Operations can be issued on every clock. A read reflects every operation issued before it, including one issued in the previous cycle.
- R6: A read returns accumulator bits [30:15] as the Q15 result when accumulator bits [39:30] are all equal.
- R7: When bits [39:30] are not all equal and `sat_en` was high on the read, the result is 0x7FFF if accumulator bit 39 is 0 and 0x8000 if it is 1. With `sat_en` low, the result is bits [30:15] unchanged (wrapping).
- R8: At least eight full-scale products of either sign can be loaded or added back to back. The sum stays exact and `acc_ovf` does not set.
- R9: When an add overflows the signed 40-bit range, the accumulator keeps the wrapped 40-bit sum and `acc_ovf` becomes 1 two cycles after that add is presented. The flag stays 1 through later adds and reads, and returns to 0 only after a clear or a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; the inputs below are taken when high |
| op | input | 2 | 00 clear, 01 load, 10 accumulate, 11 read |
| shift | input | 4 | Arithmetic right-shift amount applied to the product |
| sat_en | input | 1 | Saturate the value returned by a read |
| a | input | 16 | Q15 operand |
| b | input | 16 | Q15 operand |
| out_valid | output | 1 | One-cycle strobe for a read result |
| result | output | 16 | Q15 read result, held between reads |
| acc_ovf | output | 1 | Sticky flag: the 40-bit accumulator wrapped |

## Verification
A read presented before edge k yields its result after edge k+1. The driver therefore stores, with each expected value, the cycle number two edges on. The monitor pops an entry on every `out_valid` and compares both the value and the arrival cycle at the falling edge after the result register is written. Effects on the accumulator are observed only through later reads, which each pick up all earlier operations under the same two-cycle rule. The overflow flag is sampled two edges after the operation that should set it or clear it. By then the second stage has written the flag.

// File: rtl/mac_q15_pkg.sv
package mac_q15_pkg;
  typedef enum logic [1:0] {
    OP_CLEAR = 2'b00,
    OP_LOAD  = 2'b01,
    OP_ACCUM = 2'b10,
    OP_READ  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
  parameter int IW  = 16,
  parameter int SHW = 4,
  localparam int PW = 2 * IW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     op,
  input  logic [SHW-1:0] shift,
  input  logic           sat_en,
  input  logic [IW-1:0]  a,
  input  logic [IW-1:0]  b,
  output logic           s1_valid,
  output logic [1:0]     s1_op,
  output logic [SHW-1:0] s1_shift,
  output logic           s1_sat,
  output logic [PW-1:0]  s1_prod
);
  logic signed [PW-1:0] prod_n;

  always_comb begin
    prod_n = PW'($signed(a)) * PW'($signed(b));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_shift <= '0;
      s1_sat   <= 1'b0;
      s1_prod  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op    <= op;
        s1_shift <= shift;
        s1_sat   <= sat_en;
        s1_prod  <= prod_n;
      end
    end
  end

  // R5: every accepted operation reaches the second stage one clock later
  a_r5_stage_follows : assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);
  // R4: idle cycles do not produce a second-stage operation
  a_r4_idle_drops : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !s1_valid);
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_q15_pkg::*;
#(
  parameter int PW   = 32,
  parameter int GW   = 8,
  parameter int SHW  = 4,
  parameter int FRAC = 15,
  localparam int AW  = PW + GW,
  localparam int HW  = AW - FRAC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s_valid,
  input  logic [1:0]     s_op,
  input  logic [SHW-1:0] s_shift,
  input  logic [PW-1:0]  s_prod,
  output logic [HW-1:0]  acc_hi,
  output logic           ovf
);
  logic [AW-1:0] acc;
  logic signed [AW-1:0] stg [0:SHW];
  logic [AW-1:0] shifted;
  logic [AW-1:0] sum;
  logic          wrap;

  assign stg[0] = $signed({{GW{s_prod[PW-1]}}, s_prod});

  generate
    for (genvar i = 0; i < SHW; i++) begin : g_shift
      assign stg[i+1] = s_shift[i] ? (stg[i] >>> (1 << i)) : stg[i];
    end
  endgenerate

  assign shifted = stg[SHW];
  assign sum     = acc + shifted;
  assign wrap    = (acc[AW-1] == shifted[AW-1]) && (sum[AW-1] != acc[AW-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (s_valid) begin
      unique case (mac_op_e'(s_op))
        OP_CLEAR: begin acc <= '0;      ovf <= 1'b0; end
        OP_LOAD:  begin acc <= shifted; ovf <= 1'b0; end
        OP_ACCUM: begin acc <= sum;     ovf <= ovf | wrap; end
        default:  ;
      endcase
    end
  end

  assign acc_hi = acc[AW-1:FRAC];

  // R4: a clear leaves a zero accumulator and a cleared flag
  a_r4_clear_zero : assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_op == OP_CLEAR) |=> (acc == '0 && !ovf));
  // R4: reads and idle cycles leave the accumulator untouched
  a_r4_read_holds : assert property (@(posedge clk) disable iff (rst)
    (!s_valid || s_op == OP_READ) |=> $stable(acc));
  // R9: the overflow flag is sticky until clear or load
  a_r9_sticky_ovf : assert property (@(posedge clk) disable iff (rst)
    (ovf && !(s_valid && (s_op == OP_CLEAR || s_op == OP_LOAD))) |=> ovf);
endmodule

// File: rtl/mac_readout.sv
module mac_readout
  import mac_q15_pkg::*;
#(
  parameter int IW = 16,
  parameter int HW = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [1:0]    s_op,
  input  logic          s_sat,
  input  logic [HW-1:0] acc_hi,
  output logic          out_valid,
  output logic [IW-1:0] result
);
  localparam int TOPW = HW - IW + 1;

  logic [TOPW-1:0] top;
  logic            fits;
  logic            rd;
  logic [IW-1:0]   rd_val;

  assign top  = acc_hi[HW-1:IW-1];
  assign fits = (&top) || !(|top);
  assign rd   = s_valid && (s_op == OP_READ);

  always_comb begin
    if (!fits && s_sat)
      rd_val = acc_hi[HW-1] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    else
      rd_val = acc_hi[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= rd;
      if (rd) result <= rd_val;
    end
  end

  // R5: a result strobe appears only for a read one clock earlier
  a_r5_valid_from_read : assert property (@(posedge clk) disable iff (rst)
    rd |=> out_valid);
  a_r5_no_spurious : assert property (@(posedge clk) disable iff (rst)
    !rd |=> !out_valid);
  // R7: a saturating read of an out-of-range value returns an extreme
  a_r7_sat_extreme : assert property (@(posedge clk) disable iff (rst)
    (rd && s_sat && !fits) |=>
      (result == {1'b1, {(IW-1){1'b0}}} || result == {1'b0, {(IW-1){1'b1}}}));
endmodule

// File: rtl/mac_q15.sv
module mac_q15 #(
  parameter int IW   = 16,
  parameter int GW   = 8,
  parameter int SHW  = 4,
  localparam int PW   = 2 * IW,
  localparam int AW   = PW + GW,
  localparam int FRAC = IW - 1,
  localparam int HW   = AW - FRAC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     op,
  input  logic [SHW-1:0] shift,
  input  logic           sat_en,
  input  logic [IW-1:0]  a,
  input  logic [IW-1:0]  b,
  output logic           out_valid,
  output logic [IW-1:0]  result,
  output logic           acc_ovf
);
  logic           s1_valid;
  logic [1:0]     s1_op;
  logic [SHW-1:0] s1_shift;
  logic           s1_sat;
  logic [PW-1:0]  s1_prod;
  logic [HW-1:0]  acc_hi;

  mac_mul_stage #(.IW(IW), .SHW(SHW)) u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .shift(shift),
    .sat_en(sat_en), .a(a), .b(b),
    .s1_valid(s1_valid), .s1_op(s1_op), .s1_shift(s1_shift),
    .s1_sat(s1_sat), .s1_prod(s1_prod)
  );

  mac_acc_stage #(.PW(PW), .GW(GW), .SHW(SHW), .FRAC(FRAC)) u_acc (
    .clk(clk), .rst(rst), .s_valid(s1_valid), .s_op(s1_op),
    .s_shift(s1_shift), .s_prod(s1_prod), .acc_hi(acc_hi), .ovf(acc_ovf)
  );

  mac_readout #(.IW(IW), .HW(HW)) u_rd (
    .clk(clk), .rst(rst), .s_valid(s1_valid), .s_op(s1_op), .s_sat(s1_sat),
    .acc_hi(acc_hi), .out_valid(out_valid), .result(result)
  );

  // R1: reset leaves no pending result
  a_r1_reset_quiet : assert property (@(posedge clk)
    rst |=> (!out_valid && !acc_ovf && result == '0));
endmodule

// File: tb/mac_q15_bench.sv
module mac_q15_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] op = 2'b00;
  logic [3:0] shift = '0;
  logic sat_en = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic out_valid, acc_ovf;
  logic [15:0] result;

  always #5 clk = ~clk;

  mac_q15 u_mac_q15 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .shift(shift),
    .sat_en(sat_en), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .acc_ovf(acc_ovf)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [15:0] q_val[$];
  int          q_cyc[$];
  string       q_tag[$];

  logic [39:0] m_acc = '0;
  logic        m_ovf = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(logic [39:0] v, logic s);
    logic [9:0] t;
    t = v[39:30];
    if (&t || !(|t)) return v[30:15];
    if (s) return v[39] ? 16'h8000 : 16'h7fff;
    return v[30:15];
  endfunction

  task automatic issue(logic [1:0] o, logic [15:0] x, logic [15:0] y,
                       logic [3:0] sh, logic s, string tag);
    logic signed [31:0] p;
    logic signed [39:0] e;
    logic [39:0] sum;
    @(negedge clk);
    in_valid = 1'b1; op = o; a = x; b = y; shift = sh; sat_en = s;
    p = $signed(x) * $signed(y);
    e = p;
    e = e >>> sh;
    case (o)
      2'b00: begin m_acc = '0; m_ovf = 1'b0; end
      2'b01: begin m_acc = e; m_ovf = 1'b0; end
      2'b10: begin
        sum = m_acc + e;
        if (m_acc[39] == e[39] && sum[39] != m_acc[39]) m_ovf = 1'b1;
        m_acc = sum;
      end
      default: begin
        q_val.push_back(model_read(m_acc, s));
        q_cyc.push_back(cyc + 2);
        q_tag.push_back(tag);
      end
    endcase
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic rd(logic s, string tag);
    issue(2'b11, 16'h0, 16'h0, 4'd0, s, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_val.size() == 0) begin
        check("R5 unexpected result", {16'h0, result}, 32'hdead);
      end else begin
        string t;
        t = q_tag.pop_front();
        check(t, {16'h0, result}, {16'h0, q_val.pop_front()});
        check({t, " R5 timing"}, cyc, q_cyc.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 result", result, 0);
    check("R1 acc_ovf", acc_ovf, 0);
    rd(1'b0, "R1 zero accumulator");
    // R2 exact products
    issue(2'b01, 16'h4000, 16'h4000, 0, 0, "");
    rd(1'b0, "R2 half times half");
    issue(2'b01, 16'h8000, 16'h8000, 0, 0, "");
    rd(1'b0, "R2 R7 full scale wraps without sat");
    rd(1'b1, "R7 full scale saturates positive");
    issue(2'b01, 16'hc000, 16'h6000, 0, 0, "");
    rd(1'b0, "R2 mixed sign");
    // R3 shift with truncation
    issue(2'b01, 16'h7fff, 16'h7fff, 3, 0, "");
    rd(1'b0, "R3 shift by 3");
    issue(2'b01, 16'h8000, 16'h0001, 4, 0, "");
    rd(1'b0, "R3 negative truncation");
    issue(2'b01, 16'h8000, 16'h8000, 15, 0, "");
    rd(1'b0, "R3 shift by 15");
    // R4 ops and idle cycles
    issue(2'b01, 16'h2000, 16'h4000, 0, 0, "");
    issue(2'b10, 16'h1000, 16'h4000, 1, 0, "");
    @(negedge clk);
    in_valid = 1'b0; op = 2'b01; a = 16'h7fff; b = 16'h7fff;
    @(negedge clk);
    in_valid = 1'b0; op = 2'b00;
    rd(1'b0, "R4 idle ignored");
    rd(1'b0, "R4 read leaves accumulator");
    issue(2'b00, 16'h7fff, 16'h7fff, 0, 0, "");
    rd(1'b0, "R4 clear");
    // R5 back-to-back and R6 readout
    issue(2'b01, 16'h0123, 16'h4567, 0, 0, "");
    issue(2'b10, 16'hfedc, 16'h3210, 0, 0, "");
    rd(1'b0, "R5 R6 read after accumulate");
    issue(2'b10, 16'h7654, 16'h89ab, 2, 0, "");
    rd(1'b1, "R5 R6 back-to-back read");
    idle(1);
    // R8 eight full-scale products
    issue(2'b01, 16'h8000, 16'h8000, 0, 0, "");
    for (int i = 0; i < 7; i++) issue(2'b10, 16'h8000, 16'h8000, 0, 0, "");
    rd(1'b1, "R8 positive sum saturates on read");
    rd(1'b0, "R8 positive sum exact slice");
    idle(2);
    check("R8 no overflow positive", acc_ovf, 0);
    issue(2'b01, 16'h8000, 16'h7fff, 0, 0, "");
    for (int i = 0; i < 7; i++) issue(2'b10, 16'h8000, 16'h7fff, 0, 0, "");
    rd(1'b1, "R8 negative sum saturates");
    idle(2);
    check("R8 no overflow negative", acc_ovf, 0);
    // R9 accumulator wrap
    issue(2'b01, 16'h8000, 16'h8000, 0, 0, "");
    for (int i = 0; i < 510; i++) issue(2'b10, 16'h8000, 16'h8000, 0, 0, "");
    idle(2);
    check("R9 not yet wrapped", acc_ovf, m_ovf);
    check("R9 model state before wrap", m_ovf, 0);
    issue(2'b10, 16'h8000, 16'h8000, 0, 0, "");
    idle(2);
    check("R9 flag sets", acc_ovf, 1);
    rd(1'b1, "R9 wrapped value saturates negative");
    issue(2'b10, 16'h0001, 16'h0001, 0, 0, "");
    idle(2);
    check("R9 flag sticky", acc_ovf, 1);
    issue(2'b01, 16'h0100, 16'h0100, 0, 0, "");
    idle(2);
    check("R9 load clears flag", acc_ovf, 0);
    rd(1'b0, "R9 value after load");
    idle(3);
    check("R5 queue drained", q_val.size(), 0);
    finish_run();
  end
endmodule